// File: doc/BRIEF.md
# LWE Ciphertext Builder

This block produces one learning-with-errors ciphertext for a single plaintext bit. A request starts with a message handshake that carries the bit. The block then takes public-key rows, each made of N coefficient words followed by one right-hand-side word, from a row stream. It also takes one random selector bit per row from a separate random-bit stream. Every row whose selector is 1 is added into a set of running sums. Four parallel accumulation lanes share out the coefficient columns: lane k owns columns k, k+4, and so on. Lane 0 also owns the right-hand-side column, which it handles in a final beat after the coefficient columns.

When all M rows have been folded in, half of the modulus, floor(Q/2), is added to the right-hand-side sum if the message bit is 1. Each of the N+1 full-precision sums is then reduced modulo Q. The reducer is not inside the block: it is a shared unit elsewhere on the chip, reached through a request/acknowledge port. The reduced words leave one per beat on a valid/ready output: the N vector elements in column order come first, and the sum comes last.

Top module: `lwe_enc_engine`

## Requirements
- R1: After reset, msg_ready is 1, and out_valid, mod_req, rnd_ready and row_ready are all 0.
- R2: Exactly M random bits are accepted per message. Once the M-th bit has been taken, rnd_ready stays 0 until the next message, even while rnd_valid is held high.
- R3: Exactly M rows are accepted per message. A row is accepted only while a random bit not yet used by any row is held, so the count of accepted rows never reaches the count of accepted bits before that row's own handshake.
- R4: Output element j (0 <= j < N) equals the sum, over every row i whose bit is 1, of coefficient j of row i, taken modulo Q. Coefficient j lies at row_data bits [j*W +: W].
- R5: The final output word equals the sum, over selected rows, of the right-hand-side word (row_data bits [N*W +: W]), plus floor(Q/2) when msg_bit is 1, all taken modulo Q.
- R6: Each message yields exactly N+1 output beats, in column order with the sum last. out_last is 1 on the sum beat only.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data and out_last hold their values.
- R8: mod_req, once raised, stays 1 with mod_operand unchanged until a cycle in which mod_ack is 1. Each output beat starts only after an acknowledge.
- R9: All sums restart from zero at each message handshake, so a message that selects no rows yields all-zero vector elements even when it follows a message with large sums.
- R10: A random bit may be accepted in the same cycle that the lanes are still adding the previous row, and the result is the same as with slow delivery.
- R11: Sums keep full precision until reduction. Every row at the largest W-bit values, with every bit 1, still reduces correctly.
- R12: msg_ready is 0 from the message handshake until the final output beat is accepted, and it never coincides with out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message request valid |
| msg_ready | output | 1 | Block idle and able to take a message |
| msg_bit | input | 1 | Plaintext bit |
| rnd_valid | input | 1 | Random bit valid |
| rnd_ready | output | 1 | Random bit accepted |
| rnd_bit | input | 1 | Random selector bit for the next row |
| row_valid | input | 1 | Public row valid |
| row_ready | output | 1 | Public row accepted |
| row_data | input | (N+1)*W | N coefficient words then the right-hand-side word |
| mod_req | output | 1 | Request to the shared modulo unit |
| mod_operand | output | W+clog2(M)+1 | Full-precision value to reduce |
| mod_ack | input | 1 | Modulo result valid for one cycle |
| mod_result | input | W | Reduced value |
| out_valid | output | 1 | Ciphertext word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | W | Ciphertext word |
| out_last | output | 1 | Marks the sum word |

## Verification
Two functions can fall in the same cycle: taking the next random bit, and the lane adds of the row taken just before it. The bench provokes this by offering random bits with no gaps, so that a bit is captured in the cycle right after a row handshake while the lanes are still sweeping. It counts such cycles and requires at least one in that message. The outcome is judged by comparing every ciphertext word with sums computed in the bench. The same comparison is repeated with random gaps on all streams, random output back-pressure and random modulo latency, so the sums cannot depend on when a bit arrives relative to a sweep.

// File: rtl/lwe_pkg.sv
package lwe_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_COLLECT,
        ENG_SWEEP,
        ENG_FINISH,
        ENG_DRAIN
    } eng_state_e;

    typedef enum logic [1:0] {
        OSQ_IDLE,
        OSQ_REQ,
        OSQ_SHOW
    } osq_state_e;

endpackage

// File: rtl/lwe_coef_buf.sv
// One-entry holding slot for random selector bits, with a per-message budget.
module lwe_coef_buf #(
    parameter int M = 16,
    localparam int CW = $clog2(M + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic enable,
    input  logic rnd_valid,
    input  logic rnd_bit,
    input  logic take,
    output logic rnd_ready,
    output logic coef,
    output logic full
);

    typedef struct packed {
        logic          full;
        logic          bitv;
        logic [CW-1:0] cnt;
    } cb_st_t;

    cb_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        rnd_ready = enable && !st_q.full && (st_q.cnt < CW'(M));
        if (clr) begin
            st_d = '0;
        end else begin
            if (take) begin
                st_d.full = 1'b0;
            end
            if (rnd_ready && rnd_valid) begin
                st_d.full = 1'b1;
                st_d.bitv = rnd_bit;
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign coef = st_q.bitv;
    assign full = st_q.full;

endmodule

// File: rtl/lwe_mac_lane.sv
// One accumulation lane: CPL column sums, plus the right-hand-side sum when HAS_SUM.
module lwe_mac_lane #(
    parameter int W       = 12,
    parameter int ACCW    = 17,
    parameter int CPL     = 2,
    parameter int HAS_SUM = 0,
    parameter int HALF    = 1664,
    localparam int BW     = $clog2(CPL + 1),
    localparam int SLOTS  = CPL + ((HAS_SUM != 0) ? 1 : 0)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  add_en,
    input  logic                  sum_beat,
    input  logic                  half_en,
    input  logic [BW-1:0]         beat,
    input  logic [W-1:0]          din,
    output logic [SLOTS*ACCW-1:0] acc_out
);

    typedef struct packed {
        logic [CPL-1:0][ACCW-1:0] acc;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (add_en && !sum_beat) begin
            for (int c = 0; c < CPL; c++) begin
                if (beat == BW'(c)) begin
                    st_d.acc[c] = st_q.acc[c] + ACCW'(din);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    if (HAS_SUM != 0) begin : g_sum
        logic [ACCW-1:0] sum_d, sum_q;

        always_comb begin
            sum_d = sum_q;
            if (clr) begin
                sum_d = '0;
            end else begin
                if (add_en && sum_beat) begin
                    sum_d = sum_d + ACCW'(din);
                end
                if (half_en) begin
                    sum_d = sum_d + ACCW'(HALF);
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum_q <= '0;
            end else begin
                sum_q <= sum_d;
            end
        end

        assign acc_out = {sum_q, st_q.acc};
    end else begin : g_nosum
        logic unused_half;
        assign unused_half = half_en;
        assign acc_out     = st_q.acc;
    end

endmodule

// File: rtl/lwe_out_seq.sv
// Walks the N+1 sums through the shared modulo unit and presents each result.
module lwe_out_seq
    import lwe_pkg::*;
#(
    parameter int N    = 8,
    parameter int W    = 12,
    parameter int ACCW = 17,
    localparam int IW  = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [N:0][ACCW-1:0] elems,
    output logic                 mod_req,
    output logic [ACCW-1:0]      mod_operand,
    input  logic                 mod_ack,
    input  logic [W-1:0]         mod_result,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [W-1:0]         out_data,
    output logic                 out_last,
    output logic                 done
);

    typedef struct packed {
        osq_state_e    state;
        logic [IW-1:0] idx;
        logic [W-1:0]  data;
    } osq_st_t;

    osq_st_t st_d, st_q;
    logic    at_last;

    always_comb begin
        st_d        = st_q;
        at_last     = (st_q.idx == IW'(N));
        mod_req     = (st_q.state == OSQ_REQ);
        mod_operand = elems[st_q.idx];
        out_valid   = (st_q.state == OSQ_SHOW);
        out_last    = out_valid && at_last;
        done        = out_valid && out_ready && at_last;
        case (st_q.state)
            OSQ_IDLE: begin
                if (start) begin
                    st_d.idx   = '0;
                    st_d.state = OSQ_REQ;
                end
            end
            OSQ_REQ: begin
                if (mod_ack) begin
                    st_d.data  = mod_result;
                    st_d.state = OSQ_SHOW;
                end
            end
            OSQ_SHOW: begin
                if (out_ready) begin
                    if (at_last) begin
                        st_d.state = OSQ_IDLE;
                    end else begin
                        st_d.idx   = st_q.idx + 1'b1;
                        st_d.state = OSQ_REQ;
                    end
                end
            end
            default: st_d.state = OSQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= OSQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data = st_q.data;

endmodule

// File: rtl/lwe_enc_engine.sv
module lwe_enc_engine
    import lwe_pkg::*;
#(
    parameter int N     = 8,
    parameter int M     = 16,
    parameter int Q     = 3329,
    parameter int W     = 12,
    parameter int LANES = 4,
    localparam int ACCW = W + $clog2(M) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msg_valid,
    output logic                 msg_ready,
    input  logic                 msg_bit,
    input  logic                 rnd_valid,
    output logic                 rnd_ready,
    input  logic                 rnd_bit,
    input  logic                 row_valid,
    output logic                 row_ready,
    input  logic [(N+1)*W-1:0]   row_data,
    output logic                 mod_req,
    output logic [ACCW-1:0]      mod_operand,
    input  logic                 mod_ack,
    input  logic [W-1:0]         mod_result,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [W-1:0]         out_data,
    output logic                 out_last
);

    localparam int CPL  = N / LANES;
    localparam int BW   = $clog2(CPL + 1);
    localparam int RW   = $clog2(M + 1);
    localparam int HALF = Q / 2;

    typedef struct packed {
        eng_state_e          state;
        logic                mbit;
        logic [N:0][W-1:0]   row;
        logic                rcoef;
        logic [BW-1:0]       beat;
        logic [RW-1:0]       rows;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic                 lane_clr;
    logic                 take;
    logic                 coef;
    logic                 coef_full;
    logic                 cb_enable;
    logic                 add_en;
    logic                 sum_beat;
    logic                 half_en;
    logic                 seq_start;
    logic                 seq_done;
    logic [N:0][ACCW-1:0] elems;

    always_comb begin
        st_d      = st_q;
        msg_ready = (st_q.state == ENG_IDLE);
        row_ready = (st_q.state == ENG_COLLECT) && coef_full;
        cb_enable = (st_q.state == ENG_COLLECT) || (st_q.state == ENG_SWEEP);
        lane_clr  = msg_valid && msg_ready;
        take      = row_valid && row_ready;
        sum_beat  = (st_q.beat == BW'(CPL));
        add_en    = (st_q.state == ENG_SWEEP) && st_q.rcoef;
        half_en   = (st_q.state == ENG_FINISH) && st_q.mbit;
        seq_start = (st_q.state == ENG_FINISH);
        case (st_q.state)
            ENG_IDLE: begin
                if (lane_clr) begin
                    st_d.mbit  = msg_bit;
                    st_d.rows  = '0;
                    st_d.state = ENG_COLLECT;
                end
            end
            ENG_COLLECT: begin
                if (take) begin
                    st_d.row   = row_data;
                    st_d.rcoef = coef;
                    st_d.beat  = '0;
                    st_d.state = ENG_SWEEP;
                end
            end
            ENG_SWEEP: begin
                if (sum_beat) begin
                    st_d.rows  = st_q.rows + 1'b1;
                    st_d.state = (st_q.rows == RW'(M - 1)) ? ENG_FINISH : ENG_COLLECT;
                end else begin
                    st_d.beat = st_q.beat + 1'b1;
                end
            end
            ENG_FINISH: begin
                st_d.state = ENG_DRAIN;
            end
            ENG_DRAIN: begin
                if (seq_done) begin
                    st_d.state = ENG_IDLE;
                end
            end
            default: st_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ENG_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    lwe_coef_buf #(.M(M)) u_coef (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (lane_clr),
        .enable    (cb_enable),
        .rnd_valid (rnd_valid),
        .rnd_bit   (rnd_bit),
        .take      (take),
        .rnd_ready (rnd_ready),
        .coef      (coef),
        .full      (coef_full)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HS = (k == 0) ? 1 : 0;
        localparam int SL = CPL + HS;

        logic [W-1:0]       din;
        logic [SL*ACCW-1:0] bus;

        always_comb begin
            din = '0;
            if (sum_beat) begin
                if (HS != 0) begin
                    din = st_q.row[N];
                end
            end else begin
                for (int c = 0; c < CPL; c++) begin
                    if (st_q.beat == BW'(c)) begin
                        din = st_q.row[k + LANES * c];
                    end
                end
            end
        end

        lwe_mac_lane #(
            .W       (W),
            .ACCW    (ACCW),
            .CPL     (CPL),
            .HAS_SUM (HS),
            .HALF    (HALF)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (lane_clr),
            .add_en   (add_en),
            .sum_beat (sum_beat),
            .half_en  (half_en),
            .beat     (st_q.beat),
            .din      (din),
            .acc_out  (bus)
        );

        for (genvar c = 0; c < CPL; c++) begin : g_col
            assign elems[k + LANES * c] = bus[c * ACCW +: ACCW];
        end

        if (HS != 0) begin : g_rhs
            assign elems[N] = bus[CPL * ACCW +: ACCW];
        end
    end

    lwe_out_seq #(
        .N    (N),
        .W    (W),
        .ACCW (ACCW)
    ) u_oseq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (seq_start),
        .elems       (elems),
        .mod_req     (mod_req),
        .mod_operand (mod_operand),
        .mod_ack     (mod_ack),
        .mod_result  (mod_result),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_last    (out_last),
        .done        (seq_done)
    );

endmodule

// File: rtl/lwe_enc_engine_chk.sv
module lwe_enc_engine_chk #(
    parameter int M    = 16,
    parameter int Q    = 3329,
    parameter int W    = 12,
    parameter int ACCW = 17,
    localparam int KW  = $clog2(M + 1) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            msg_valid,
    input logic            msg_ready,
    input logic            rnd_valid,
    input logic            rnd_ready,
    input logic            row_valid,
    input logic            row_ready,
    input logic            mod_req,
    input logic [ACCW-1:0] mod_operand,
    input logic            mod_ack,
    input logic            out_valid,
    input logic            out_ready,
    input logic [W-1:0]    out_data,
    input logic            out_last
);

    logic [KW-1:0] rnd_cnt;
    logic [KW-1:0] row_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_cnt <= '0;
            row_cnt <= '0;
        end else if (msg_valid && msg_ready) begin
            rnd_cnt <= '0;
            row_cnt <= '0;
        end else begin
            if (rnd_valid && rnd_ready) rnd_cnt <= rnd_cnt + 1'b1;
            if (row_valid && row_ready) row_cnt <= row_cnt + 1'b1;
        end
    end

    assert_rnd_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_valid && rnd_ready) |-> (rnd_cnt < KW'(M)));

    assert_row_after_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && row_ready) |-> (row_cnt < rnd_cnt));

    assert_reduced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data < W'(Q)));

    assert_last_on_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_mod_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && !mod_ack) |=> (mod_req && $stable(mod_operand)));

    assert_beat_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(mod_ack));

    assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !msg_ready);

endmodule

bind lwe_enc_engine lwe_enc_engine_chk #(
    .M    (M),
    .Q    (Q),
    .W    (W),
    .ACCW (ACCW)
) u_chk (.*);

// File: tb/sim_lwe_enc_engine.sv
`timescale 1ns/1ps
module sim_lwe_enc_engine;

    localparam int N    = 8;
    localparam int M    = 16;
    localparam int Q    = 3329;
    localparam int W    = 12;
    localparam int ACCW = W + $clog2(M) + 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                msg_valid = 1'b0;
    logic                msg_ready;
    logic                msg_bit = 1'b0;
    logic                rnd_valid = 1'b0;
    logic                rnd_ready;
    logic                rnd_bit = 1'b0;
    logic                row_valid = 1'b0;
    logic                row_ready;
    logic [(N+1)*W-1:0]  row_data = '0;
    logic                mod_req;
    logic [ACCW-1:0]     mod_operand;
    logic                mod_ack = 1'b0;
    logic [W-1:0]        mod_result = '0;
    logic                out_valid;
    logic                out_ready = 1'b0;
    logic [W-1:0]        out_data;
    logic                out_last;

    always #10 clk = ~clk;

    lwe_enc_engine #(.N(N), .M(M), .Q(Q), .W(W)) u0 (.*);

    int nchk = 0, nfail = 0;
    bit finished = 0;

    int coefs [M];
    int rows_a [M][N+1];
    int msgv;
    int exp_v [N+1];
    int got_v [N+1];
    int got_l [N+1];
    int beat_cnt, rnd_hs, row_hs, row_early, overlap, hold_viol, mod_viol, busy_viol;
    int rdy_pct = 100, rnd_gap = 0, row_gap = 0;

    task automatic chk(string req, int act, int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic void compute_expected();
        for (int j = 0; j <= N; j++) begin
            int acc = 0;
            for (int i = 0; i < M; i++) if (coefs[i] != 0) acc += rows_a[i][j];
            if (j == N && msgv != 0) acc += Q / 2;
            exp_v[j] = acc % Q;
        end
    endfunction

    // shared modulo unit model with random latency
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (mod_ack) begin
                mod_ack = 1'b0;
            end else if (mod_req) begin
                if (dly == 0) begin
                    mod_ack    = 1'b1;
                    mod_result = W'(int'(mod_operand) % Q);
                    dly        = int'($urandom % 4);
                end else begin
                    dly--;
                end
            end
        end
    end

    // output consumer and port monitors, sampled after the falling edge
    initial begin
        bit pv = 0, pr = 0, pq = 0, pa = 0, prow = 0;
        logic [W-1:0] pd = '0;
        logic [ACCW-1:0] po = '0;
        forever begin
            @(negedge clk);
            #1;
            out_ready = (($urandom % 100) < rdy_pct);
            if (pv && !pr && (!out_valid || out_data != pd)) hold_viol++;
            if (pq && !pa && (!mod_req || mod_operand != po)) mod_viol++;
            if (out_valid && msg_ready) busy_viol++;
            if (rnd_valid && rnd_ready) begin
                if (prow) overlap++;
                rnd_hs++;
            end
            prow = 0;
            if (row_valid && row_ready) begin
                if (row_hs >= rnd_hs) row_early++;
                row_hs++;
                prow = 1;
            end
            if (out_valid && out_ready) begin
                if (beat_cnt <= N) begin
                    got_v[beat_cnt] = int'(out_data);
                    got_l[beat_cnt] = int'(out_last);
                end
                beat_cnt++;
            end
            pv = out_valid; pr = out_ready; pd = out_data;
            pq = mod_req; pa = mod_ack; po = mod_operand;
        end
    end

    task automatic feed_msg();
        @(negedge clk);
        msg_valid = 1'b1;
        msg_bit   = msgv[0];
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic feed_rnd();
        for (int i = 0; i < M; i++) begin
            int g = (rnd_gap > 0) ? int'($urandom % (rnd_gap + 1)) : 0;
            @(negedge clk);
            if (g > 0) begin
                rnd_valid = 1'b0;
                repeat (g) @(negedge clk);
            end
            rnd_valid = 1'b1;
            rnd_bit   = coefs[i][0];
            while (!rnd_ready) @(negedge clk);
        end
        @(negedge clk);
        rnd_bit = 1'b1;   // extra bit stays offered: must not be taken
    endtask

    task automatic feed_rows();
        for (int i = 0; i < M; i++) begin
            int g = (row_gap > 0) ? int'($urandom % (row_gap + 1)) : 0;
            @(negedge clk);
            if (g > 0) begin
                row_valid = 1'b0;
                repeat (g) @(negedge clk);
            end
            row_valid = 1'b1;
            for (int j = 0; j <= N; j++) row_data[j*W +: W] = W'(rows_a[i][j]);
            while (!row_ready) @(negedge clk);
        end
        @(negedge clk);
        row_data = '1;    // extra row stays offered: must not be taken
    endtask

    task automatic run_msg(bit after_big);
        int lastbad = 0;
        int nonzero = 0;
        compute_expected();
        beat_cnt = 0; rnd_hs = 0; row_hs = 0; row_early = 0; overlap = 0;
        hold_viol = 0; mod_viol = 0; busy_viol = 0;
        fork
            feed_msg();
            feed_rnd();
            feed_rows();
        join
        wait (beat_cnt >= N + 1);
        repeat (3) @(negedge clk);
        for (int j = 0; j <= N; j++) begin
            if (j < N) chk("R4", got_v[j], exp_v[j]);
            else       chk("R5", got_v[j], exp_v[j]);
            if (got_l[j] != ((j == N) ? 1 : 0)) lastbad++;
            if (j < N && got_v[j] != 0) nonzero++;
        end
        chk("R6", lastbad, 0);
        chk("R6", beat_cnt, N + 1);
        chk("R2", rnd_hs, M);
        chk("R2", int'(rnd_ready), 0);
        chk("R3", row_hs, M);
        chk("R3", row_early, 0);
        chk("R7", hold_viol, 0);
        chk("R8", mod_viol, 0);
        chk("R12", busy_viol, 0);
        chk("R12", int'(msg_ready), 1);
        if (after_big) chk("R9", nonzero, 0);
        rnd_valid = 1'b0;
        row_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk("R1", int'(msg_ready), 1);
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(mod_req), 0);
        chk("R1", int'(rnd_ready), 0);
        chk("R1", int'(row_ready), 0);

        // R11: every row at the largest value, every bit set, message 1; no gaps (R10)
        for (int i = 0; i < M; i++) begin
            coefs[i] = 1;
            for (int j = 0; j <= N; j++) rows_a[i][j] = (1 << W) - 1;
        end
        msgv = 1; rdy_pct = 100; rnd_gap = 0; row_gap = 0;
        run_msg(0);
        chk("R11", got_v[N], ((M * ((1 << W) - 1)) + Q / 2) % Q);
        chk("R10", int'(overlap > 0), 1);

        // R9: nothing selected right after large sums
        for (int i = 0; i < M; i++) begin
            coefs[i] = 0;
            for (int j = 0; j <= N; j++) rows_a[i][j] = int'($urandom % (1 << W));
        end
        msgv = 0; rdy_pct = 50;
        run_msg(1);

        // R5: nothing selected, message 1 gives half of Q
        msgv = 1;
        run_msg(1);
        chk("R5", got_v[N], Q / 2);

        // only the final row selected, slow random bits
        coefs[M-1] = 1; msgv = 0; rnd_gap = 3; row_gap = 0;
        run_msg(0);

        // random messages under random gaps, back-pressure and modulo latency
        for (int t = 0; t < 20; t++) begin
            for (int i = 0; i < M; i++) begin
                coefs[i] = int'($urandom % 2);
                for (int j = 0; j <= N; j++) rows_a[i][j] = int'($urandom % (1 << W));
            end
            msgv    = int'($urandom % 2);
            rdy_pct = 30 + int'($urandom % 71);
            rnd_gap = int'($urandom % 4);
            row_gap = int'($urandom % 4);
            run_msg(0);
        end
        finish_run();
    end

endmodule